// File: doc/BRIEF.md
# Serial Memory Target Read Engine

This block is the target side of a two-wire serial memory with byte addresses, limited to reading. It oversamples the clock and data lines with the system clock and finds start, repeated-start and stop conditions. It compares the device select byte with a configured code. It keeps an address counter that a write-direction phase loads, and it returns bytes from a small array, one after another, during read-direction phases. The array is filled with a fixed pattern at reset. The data line is open drain: the block only ever pulls it low.

The master has two ways to read. It can send a device select with a write direction and one address byte, then a repeated start and a read-direction device select. Or it can go straight to a read-direction select and continue from the current address. While the busy input reports an internal write cycle, the device select gets no acknowledge, so the master can poll until the memory is ready. The write-control input only decides whether data bytes in the write direction are acknowledged. It never changes how reads behave.

Top module: `ee_rd_target`

## Requirements
- R1: After reset, and after any STOP, the data line is released and the engine waits for a START. A START at any point, even in the middle of a byte, restarts device-select matching. The address counter keeps its value in both cases.
- R2: A device select byte is sent MSB first. Its upper 7 bits must equal DEV_CODE (default 7'b1010000) and its LSB is the direction, where 1 means read. On a mismatch the block gives no acknowledge and drives nothing until the next START.
- R3: While busy_i is high at the end of a device select byte, the block does not acknowledge.
- R4: In the write direction the block acknowledges the address byte and loads its low log2(DEPTH) bits into the address counter. A data byte after that is acknowledged only when wc_i is low. Data bytes change neither the array nor the counter.
- R5: After acknowledging a read-direction select, the block drives the byte at the address counter MSB first. It changes the data line only while SCL is low.
- R6: The counter steps by one after each output byte and wraps from DEPTH-1 to 0. While the master acknowledges, the next byte follows.
- R7: A master no-acknowledge ends the output and the block releases the data line. Any further clocks read back 8'hFF.
- R8: Reads return the same data whatever the level of wc_i.
- R9: Array entry i holds (i*37 + 90) mod 256. A read straight after reset starts at address 0.
- R10: A current-address read continues from where the last read or address load left the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy_i | input | 1 | Internal write cycle in progress |
| wc_i | input | 1 | Write-control level |

## Verification
On a single SCL falling edge the counter both steps and wraps. The bench provokes this by reading across the top address and expects entry DEPTH-1, then entry 0, then entry 1. A START can also arrive while the engine is part-way through an address byte. That is provoked by cutting the byte after four bits, and it is judged by a following current-address read that must return the counter value from before the interrupted phase.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } eng_state_e;

    // Fill pattern held by the array after reset.
    function automatic logic [BYTE_W-1:0] seed_byte(input int unsigned idx);
        return BYTE_W'((idx * 37 + 90) % 256);
    endfunction

endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    localparam int HW = STAGES + 1;

    logic [HW-1:0] scl_d, scl_q;
    logic [HW-1:0] sda_d, sda_q;
    logic          scl_prev, sda_prev;

    always_comb begin
        scl_d = {scl_q[HW-2:0], scl_i};
        sda_d = {sda_q[HW-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_s    = scl_q[HW-2];
    assign sda_s    = sda_q[HW-2];
    assign scl_prev = scl_q[HW-1];
    assign sda_prev = sda_q[HW-1];

    assign scl_rise = scl_s & ~scl_prev;
    assign scl_fall = ~scl_s & scl_prev;
    assign start_p  = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_p   = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/ee_seed_array.sv
module ee_seed_array
    import ee_rd_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     raddr,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic [BYTE_W-1:0] rd_d, rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= seed_byte(i);
            end
        end
    end

    always_comb begin
        rd_d = mem_q[raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q;

endmodule

// File: rtl/ee_rd_target.sv
module ee_rd_target
    import ee_rd_pkg::*;
#(
    parameter logic [6:0] DEV_CODE = 7'b1010000,
    parameter int         DEPTH    = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    input  logic busy_i,
    input  logic wc_i
);
    localparam int         AW       = $clog2(DEPTH);
    localparam logic [3:0] BITS     = 4'(BYTE_W);
    localparam logic [AW-1:0] TOP_A = AW'(DEPTH - 1);

    typedef struct packed {
        eng_state_e        state;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] tx;
        logic              oe;
        logic              rnw;
        logic              mack;
        logic [AW-1:0]     addr;
    } eng_t;

    logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic [BYTE_W-1:0] rdata;
    eng_t st_d, st_q;

    ee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    ee_seed_array #(.DEPTH(DEPTH)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (st_q.addr),
        .rdata (rdata)
    );

    always_comb begin
        st_d = st_q;
        case (st_q.state)
            ST_DEV: begin
                if (scl_rise) begin
                    st_d.sh  = {st_q.sh[BYTE_W-2:0], sda_s};
                    st_d.cnt = st_q.cnt + 4'd1;
                end else if (scl_fall && st_q.cnt == BITS) begin
                    if (st_q.sh[7:1] == DEV_CODE && !busy_i) begin
                        st_d.state = ST_DEV_ACK;
                        st_d.oe    = 1'b1;
                        st_d.rnw   = st_q.sh[0];
                    end else begin
                        st_d.state = ST_IGNORE;
                    end
                end
            end
            ST_DEV_ACK: begin
                if (scl_fall) begin
                    st_d.cnt = '0;
                    if (st_q.rnw) begin
                        st_d.state = ST_TX;
                        st_d.tx    = rdata;
                        st_d.oe    = ~rdata[BYTE_W-1];
                    end else begin
                        st_d.state = ST_ADDR;
                        st_d.oe    = 1'b0;
                    end
                end
            end
            ST_ADDR: begin
                if (scl_rise) begin
                    st_d.sh  = {st_q.sh[BYTE_W-2:0], sda_s};
                    st_d.cnt = st_q.cnt + 4'd1;
                end else if (scl_fall && st_q.cnt == BITS) begin
                    st_d.state = ST_ADDR_ACK;
                    st_d.oe    = 1'b1;
                end
            end
            ST_ADDR_ACK: begin
                if (scl_fall) begin
                    st_d.addr  = st_q.sh[AW-1:0];
                    st_d.state = ST_DATA;
                    st_d.oe    = 1'b0;
                    st_d.cnt   = '0;
                end
            end
            ST_DATA: begin
                if (scl_rise) begin
                    st_d.cnt = st_q.cnt + 4'd1;
                end else if (scl_fall && st_q.cnt == BITS) begin
                    if (!wc_i) begin
                        st_d.state = ST_DATA_ACK;
                        st_d.oe    = 1'b1;
                    end else begin
                        st_d.state = ST_IGNORE;
                    end
                end
            end
            ST_DATA_ACK: begin
                if (scl_fall) begin
                    st_d.state = ST_DATA;
                    st_d.oe    = 1'b0;
                    st_d.cnt   = '0;
                end
            end
            ST_TX: begin
                if (scl_rise) begin
                    st_d.cnt = st_q.cnt + 4'd1;
                end else if (scl_fall) begin
                    if (st_q.cnt == BITS) begin
                        st_d.state = ST_TX_ACK;
                        st_d.oe    = 1'b0;
                        st_d.addr  = (st_q.addr == TOP_A) ? '0 : st_q.addr + 1'b1;
                    end else begin
                        st_d.tx = {st_q.tx[BYTE_W-2:0], 1'b0};
                        st_d.oe = ~st_q.tx[BYTE_W-2];
                    end
                end
            end
            ST_TX_ACK: begin
                if (scl_rise) begin
                    st_d.mack = ~sda_s;
                end else if (scl_fall) begin
                    if (st_q.mack) begin
                        st_d.state = ST_TX;
                        st_d.tx    = rdata;
                        st_d.oe    = ~rdata[BYTE_W-1];
                        st_d.cnt   = '0;
                    end else begin
                        st_d.state = ST_IDLE;
                        st_d.oe    = 1'b0;
                    end
                end
            end
            default: ;
        endcase

        if (start_p) begin
            st_d.state = ST_DEV;
            st_d.cnt   = '0;
            st_d.oe    = 1'b0;
        end else if (stop_p) begin
            st_d.state = ST_IDLE;
            st_d.oe    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, cnt: '0, sh: '0, tx: '0, oe: 1'b0,
                      rnw: 1'b0, mack: 1'b0, addr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe = st_q.oe;

    // R5: the data line only moves in a cycle that followed SCL low
    a_r5_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

    // R1: a STOP leaves the engine idle with the line released
    a_r1_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_p) |-> (st_q.state == ST_IDLE && !sda_oe));

    // R3: an acknowledge after a select byte never starts while busy
    a_r3_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && $past(st_q.state) == ST_DEV) |-> !$past(busy_i));

    // R6: outside an address load the counter only steps by one, wrapping
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(st_q.addr) && $past(st_q.state) != ST_ADDR_ACK) |->
        st_q.addr == (($past(st_q.addr) == TOP_A) ? '0 : $past(st_q.addr) + 1'b1));

    // R7: in listening and master-acknowledge phases the line is released
    a_r7_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state inside {ST_IDLE, ST_IGNORE, ST_DEV, ST_ADDR, ST_DATA, ST_TX_ACK})
        |-> !sda_oe);

endmodule

// File: tb/ee_rd_target_tb.sv
module ee_rd_target_tb;
    import ee_rd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int DEPTH      = 16;
    localparam int NVEC       = 5;
    // vector: {start address[12:5], byte count[4:1], wc level[0]}
    localparam logic [12:0] VECS [NVEC] = '{
        {8'd3,  4'd2, 1'b0},
        {8'd7,  4'd1, 1'b1},
        {8'd15, 4'd3, 1'b0},
        {8'd0,  4'd4, 1'b1},
        {8'd9,  4'd2, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;
    logic wc = 1'b0;
    logic sda_oe;
    logic sda_line;
    int   total = 0;
    int   fails = 0;
    int   oe_hits = 0;
    bit   done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    ee_rd_target #(.DEPTH(DEPTH)) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .busy_i (busy),
        .wc_i   (wc)
    );

    function automatic logic [7:0] exp_byte(input int a);
        return 8'(((a % DEPTH) * 37 + 90) % 256);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) begin
            @(negedge clk);
            if (sda_oe) oe_hits++;
        end
    endtask

    task automatic clk_bit(input logic v, output logic s);
        sda_m = v; wq();
        scl_m = 1'b1; wq();
        s = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic do_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(~give_ack, s);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        logic       s;
        int         exp_addr;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 reset release", sda_oe, 0);

        // R9: current read right after reset starts at 0
        do_start();
        wr_byte(8'hA1, ack);
        check("R2 read select ack", ack, 1);
        rd_byte(1'b1, d);
        check("R9 first byte", d, exp_byte(0));
        rd_byte(1'b0, d);
        check("R6 next byte", d, exp_byte(1));
        exp_addr = 2;
        // R7: released after NACK
        repeat (4) @(negedge clk);
        check("R7 line released", sda_oe, 0);
        rd_byte(1'b0, d);
        check("R7 no drive after nack", d, 8'hFF);
        do_stop();

        // Table: dummy write then repeated-start reads (R4, R5, R6, R8)
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] va;
            logic [3:0] vn;
            va = VECS[v][12:5];
            vn = VECS[v][4:1];
            wc = VECS[v][0];
            do_start();
            wr_byte(8'hA0, ack);
            check("R2 write select ack", ack, 1);
            wr_byte(va, ack);
            check("R4 address ack", ack, 1);
            do_start();
            wr_byte(8'hA1, ack);
            check("R5 read select ack", ack, 1);
            for (int k = 0; k < int'(vn); k++) begin
                rd_byte(k != int'(vn) - 1, d);
                check("R8 R6 sequential data", d, exp_byte(int'(va) + k));
            end
            do_stop();
            exp_addr = (int'(va) + int'(vn)) % DEPTH;
        end
        wc = 1'b0;

        // R10: current read continues after STOP
        do_start();
        wr_byte(8'hA1, ack);
        rd_byte(1'b0, d);
        check("R10 counter kept", d, exp_byte(exp_addr));
        exp_addr = (exp_addr + 1) % DEPTH;
        do_stop();

        // R3: busy blocks acknowledge
        busy = 1'b1;
        do_start();
        wr_byte(8'hA1, ack);
        check("R3 busy nack", ack, 0);
        do_stop();
        busy = 1'b0;

        // R2: mismatching code is ignored
        oe_hits = 0;
        do_start();
        wr_byte(8'hA2, ack);
        check("R2 mismatch nack", ack, 0);
        wr_byte(8'h00, ack);
        check("R2 rest ignored", oe_hits, 0);
        do_stop();

        // R4: data bytes acked by wc level, contents and counter untouched
        do_start();
        wr_byte(8'hA0, ack);
        wr_byte(8'h05, ack);
        check("R4 address ack", ack, 1);
        wc = 1'b0;
        wr_byte(8'h00, ack);
        check("R4 data ack wc low", ack, 1);
        wc = 1'b1;
        wr_byte(8'h00, ack);
        check("R4 data nack wc high", ack, 0);
        do_stop();
        wc = 1'b0;
        do_start();
        wr_byte(8'hA1, ack);
        rd_byte(1'b0, d);
        check("R4 array unchanged", d, exp_byte(5));
        do_stop();

        // R1: START in the middle of an address byte
        do_start();
        wr_byte(8'hA0, ack);
        for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
        do_start();
        wr_byte(8'hA1, ack);
        check("R1 select after mid-byte start", ack, 1);
        rd_byte(1'b0, d);
        check("R1 counter kept", d, exp_byte(6));
        do_stop();
        check("R1 idle after stop", sda_oe, 0);

        finish_run();
    end

endmodule